// File: doc/BRIEF.md
# Packed Palette RAM Write Port

This block holds a 256-entry colour lookup table, with 8 bits each of red, green and blue per entry, and fills it from a host bus through a narrow register window. Software first loads an index register with a group base. It then writes 32-bit colour words, each carrying four bytes of a continuous red/green/blue byte stream. Three words fill exactly four entries. Because a word boundary cuts through triplets, the block tracks the position within the twelve-byte group with a byte cursor. It keeps the red and green bytes of an unfinished triplet until the blue byte arrives.

Pixel indices enter a synchronous read port, and the looked-up colour appears one clock later. A video control byte is stored and read back whole, and its enable bit forces the colour output to black when clear. A small file of indirectly addressed DAC control bytes is also held for readback. Its slot is selected by the low bits of the index register.

Top module: `palram_top`

## Requirements
- R1: After reset the index register, the byte cursor, the video control byte and every DAC control byte read back as zero, and `rgb_o` is zero.
- R2: Write select codes are 0 index, 1 colour data, 2 DAC control and 3 video control. A write to code 0 stores `wr_data_i[7:0]` in the index register, and a write to code 3 stores all 8 bits of `wr_data_i[7:0]` in the video control byte. Read select code 0 returns the index register and code 3 returns the video control byte, both zero-extended to 32 bits.
- R3: After an index write of value V, three colour-data words fill entries B to B+3, where B is V with its two low bits cleared. Bytes are taken most-significant first, and the channel order red, green, blue runs on across word boundaries.
- R4: An index write puts the cursor back at the red byte of the new group's first entry. Any bytes already taken from an unfinished group are then dropped.
- R5: An entry changes only when its blue byte is written. After the first word only entry B is new. After the second word entry B+1 is new and B+2 still holds its old value.
- R6: `rgb_o` = {red, green, blue} (red in bits 23:16) of the entry indexed by `pix_i` at the previous rising clock edge. A colour write becomes visible to reads issued on the following cycle.
- R7: After the twelfth byte of a group, the base moves up by 4 without an index write, wrapping from 252 to 0. Further colour words then fill the next group.
- R8: Bit 6 of the video control byte enables video. When it is clear, `rgb_o` is zero. The other seven bits have no effect on `rgb_o`.
- R9: A write to code 2 stores `wr_data_i[7:0]` in DAC control slot `index[2:0]`. Read select code 2 returns the slot chosen by the current index register, zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 2 | Host write register select |
| wr_data_i | input | 32 | Host write data |
| rd_sel_i | input | 2 | Host read register select |
| rd_data_o | output | 32 | Host read data (combinational) |
| pix_i | input | 8 | Pixel index for lookup |
| rgb_o | output | 24 | Looked-up colour, blanked when video is disabled |

## Verification
The assertions assume that a host write strobe lasts one cycle per register access. They also assume that colour words within a group come only after an index write or after a completed group, so the cursor is always on a word boundary. The bench drives every access through a single write task that holds the strobe for exactly one cycle. It also always starts a scenario with an index write, which keeps the stimulus inside those assumptions. Deliberately abandoned groups are only ever cut short by another index write.

// File: rtl/palram_pkg.sv
package palram_pkg;
  localparam int CH_W = 8;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  typedef enum logic [1:0] {
    SEL_INDEX = 2'd0,
    SEL_CDATA = 2'd1,
    SEL_DAC   = 2'd2,
    SEL_VCTL  = 2'd3
  } sel_e;

  localparam int VIDEO_BIT = 6;
endpackage

// File: rtl/palram_unpack.sv
module palram_unpack
  import palram_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int BUS_W   = 32,
  parameter int COMMITS = 2,
  parameter int CUR_W   = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            idx_wr_i,
  input  logic [IDX_W-1:0]                idx_data_i,
  input  logic                            data_wr_i,
  input  logic [BUS_W-1:0]                word_i,
  output logic [IDX_W-1:0]                idx_o,
  output logic [CUR_W-1:0]                cursor_o,
  output logic [COMMITS-1:0]              cm_vld_o,
  output logic [COMMITS-1:0][IDX_W-1:0]   cm_idx_o,
  output rgb_t [COMMITS-1:0]              cm_rgb_o
);
  localparam int LANES     = BUS_W / CH_W;
  localparam int GRP_BYTES = 3 * LANES;
  localparam int GRP_W     = IDX_W - 2;
  localparam logic [CUR_W-1:0] LAST_WORD = CUR_W'(GRP_BYTES - LANES);

  logic [IDX_W-1:0] idx_q;
  logic [CUR_W-1:0] cursor_q;
  logic [CH_W-1:0]  hold_r_q, hold_g_q;
  logic [CH_W-1:0]  run_r, run_g;

  // walk the lanes MSB first, carrying partial red/green across lanes
  always_comb begin
    logic [1:0]       slot;
    logic [CUR_W-1:0] pos;
    logic [CH_W-1:0]  byte_v;
    logic [CUR_W-1:0] ent;
    run_r    = hold_r_q;
    run_g    = hold_g_q;
    slot     = '0;
    cm_vld_o = '0;
    cm_idx_o = '0;
    cm_rgb_o = '0;
    for (int i = 0; i < LANES; i++) begin
      pos    = cursor_q + CUR_W'(i);
      byte_v = word_i[BUS_W-1-CH_W*i -: CH_W];
      ent    = pos / CUR_W'(3);
      case (pos % CUR_W'(3))
        CUR_W'(0): run_r = byte_v;
        CUR_W'(1): run_g = byte_v;
        default: begin
          if (data_wr_i) begin
            cm_vld_o[slot[0]] = 1'b1;
            cm_idx_o[slot[0]] = {idx_q[IDX_W-1:2], ent[1:0]};
            cm_rgb_o[slot[0]] = '{r: run_r, g: run_g, b: byte_v};
          end
          slot = slot + 2'd1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      cursor_q <= '0;
      hold_r_q <= '0;
      hold_g_q <= '0;
    end else if (idx_wr_i) begin
      idx_q    <= idx_data_i;
      cursor_q <= '0;
    end else if (data_wr_i) begin
      hold_r_q <= run_r;
      hold_g_q <= run_g;
      if (cursor_q == LAST_WORD) begin
        cursor_q         <= '0;
        idx_q[IDX_W-1:2] <= idx_q[IDX_W-1:2] + GRP_W'(1);
      end else begin
        cursor_q <= cursor_q + CUR_W'(LANES);
      end
    end
  end

  assign idx_o    = idx_q;
  assign cursor_o = cursor_q;
endmodule

// File: rtl/palram_store.sv
module palram_store
  import palram_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int COMMITS = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [COMMITS-1:0]            cm_vld_i,
  input  logic [COMMITS-1:0][IDX_W-1:0] cm_idx_i,
  input  rgb_t [COMMITS-1:0]            cm_rgb_i,
  input  logic [IDX_W-1:0]              pix_i,
  output rgb_t                          rd_o
);
  rgb_t mem_q [ENTRIES];
  rgb_t rd_q;

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < COMMITS; k++) begin
      if (cm_vld_i[k]) mem_q[cm_idx_i[k]] <= cm_rgb_i[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= mem_q[pix_i];
  end

  assign rd_o = rd_q;
endmodule

// File: rtl/palram_ctrl.sv
module palram_ctrl
  import palram_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int BUS_W    = 32,
  parameter int DAC_REGS = 8,
  localparam int DAC_W   = $clog2(DAC_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dac_wr_i,
  input  logic              vctl_wr_i,
  input  logic [CH_W-1:0]   wr_byte_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [1:0]        rd_sel_i,
  output logic [CH_W-1:0]   vctl_o,
  output logic [BUS_W-1:0]  rd_data_o
);
  logic [CH_W-1:0] vctl_q;
  logic [CH_W-1:0] dac_q [DAC_REGS];
  logic [DAC_W-1:0] slot;

  assign slot = idx_i[DAC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vctl_q <= '0;
      for (int k = 0; k < DAC_REGS; k++) dac_q[k] <= '0;
    end else begin
      if (vctl_wr_i) vctl_q <= wr_byte_i;
      if (dac_wr_i)  dac_q[slot] <= wr_byte_i;
    end
  end

  always_comb begin
    case (sel_e'(rd_sel_i))
      SEL_INDEX: rd_data_o = BUS_W'(idx_i);
      SEL_DAC:   rd_data_o = BUS_W'(dac_q[slot]);
      SEL_VCTL:  rd_data_o = BUS_W'(vctl_q);
      default:   rd_data_o = '0;
    endcase
  end

  assign vctl_o = vctl_q;
endmodule

// File: rtl/palram_top.sv
module palram_top
  import palram_pkg::*;
#(
  parameter int ENTRIES  = 256,
  parameter int BUS_W    = 32,
  parameter int DAC_REGS = 8,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int LANES   = BUS_W / CH_W,
  localparam int COMMITS = LANES / 3 + 1,
  localparam int CUR_W   = $clog2(3 * LANES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [BUS_W-1:0] wr_data_i,
  input  logic [1:0]       rd_sel_i,
  output logic [BUS_W-1:0] rd_data_o,
  input  logic [IDX_W-1:0] pix_i,
  output logic [3*CH_W-1:0] rgb_o
);
  logic idx_wr, data_wr, dac_wr, vctl_wr;
  logic [IDX_W-1:0]              idx_w;
  logic [CUR_W-1:0]              cursor_w;
  logic [COMMITS-1:0]            cm_vld_w;
  logic [COMMITS-1:0][IDX_W-1:0] cm_idx_w;
  rgb_t [COMMITS-1:0]            cm_rgb_w;
  rgb_t                          pal_q;
  logic [CH_W-1:0]               vctl_w;

  assign idx_wr  = wr_en_i && (sel_e'(wr_sel_i) == SEL_INDEX);
  assign data_wr = wr_en_i && (sel_e'(wr_sel_i) == SEL_CDATA);
  assign dac_wr  = wr_en_i && (sel_e'(wr_sel_i) == SEL_DAC);
  assign vctl_wr = wr_en_i && (sel_e'(wr_sel_i) == SEL_VCTL);

  palram_unpack #(
    .IDX_W(IDX_W), .BUS_W(BUS_W), .COMMITS(COMMITS), .CUR_W(CUR_W)
  ) u_unpack (
    .clk_i, .rst_ni,
    .idx_wr_i  (idx_wr),
    .idx_data_i(wr_data_i[IDX_W-1:0]),
    .data_wr_i (data_wr),
    .word_i    (wr_data_i),
    .idx_o     (idx_w),
    .cursor_o  (cursor_w),
    .cm_vld_o  (cm_vld_w),
    .cm_idx_o  (cm_idx_w),
    .cm_rgb_o  (cm_rgb_w)
  );

  palram_store #(.ENTRIES(ENTRIES), .COMMITS(COMMITS)) u_store (
    .clk_i, .rst_ni,
    .cm_vld_i(cm_vld_w),
    .cm_idx_i(cm_idx_w),
    .cm_rgb_i(cm_rgb_w),
    .pix_i,
    .rd_o    (pal_q)
  );

  palram_ctrl #(.IDX_W(IDX_W), .BUS_W(BUS_W), .DAC_REGS(DAC_REGS)) u_ctrl (
    .clk_i, .rst_ni,
    .dac_wr_i (dac_wr),
    .vctl_wr_i(vctl_wr),
    .wr_byte_i(wr_data_i[CH_W-1:0]),
    .idx_i    (idx_w),
    .rd_sel_i,
    .vctl_o   (vctl_w),
    .rd_data_o
  );

  // blanking after the RAM register
  assign rgb_o = vctl_w[VIDEO_BIT] ? pal_q : '0;
endmodule

// File: rtl/palram_chk.sv
module palram_chk #(
  parameter int IDX_W   = 8,
  parameter int CUR_W   = 4,
  parameter int COMMITS = 2,
  parameter int RGB_W   = 24
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [1:0]         wr_sel_i,
  input logic               vid_bit_i,
  input logic [RGB_W-1:0]   rgb_o,
  input logic [CUR_W-1:0]   cursor_i,
  input logic [IDX_W-1:0]   idx_i,
  input logic [COMMITS-1:0] cm_vld_i
);
  localparam int GRP_W = IDX_W - 2;

  assert_cursor_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cursor_i == CUR_W'(0) || cursor_i == CUR_W'(4) || cursor_i == CUR_W'(8));

  assert_commit_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd1) |->
      ($countones(cm_vld_i) == ((cursor_i == CUR_W'(8)) ? 2 : 1)));

  assert_cursor_home_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd0) |=> cursor_i == '0);

  assert_commit_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cm_vld_i != '0) |-> (wr_en_i && wr_sel_i == 2'd1));

  assert_group_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd1 && cursor_i == CUR_W'(8)) |=>
      (cursor_i == '0 && idx_i[IDX_W-1:2] == GRP_W'($past(idx_i[IDX_W-1:2]) + GRP_W'(1))));

  assert_blank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd3 && !vid_bit_i) |=> rgb_o == '0);
endmodule

bind palram_top palram_chk #(
  .IDX_W(IDX_W), .CUR_W(CUR_W), .COMMITS(COMMITS), .RGB_W(3 * palram_pkg::CH_W)
) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_sel_i,
  .vid_bit_i(wr_data_i[palram_pkg::VIDEO_BIT]),
  .rgb_o,
  .cursor_i (cursor_w),
  .idx_i    (idx_w),
  .cm_vld_i (cm_vld_w)
);

// File: tb/sim_palram_top.sv
module sim_palram_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic [7:0]  pix = '0;
  logic [23:0] rgb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [23:0] model [256];

  always #4 clk = ~clk;

  palram_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .pix_i(pix), .rgb_o(rgb)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] col(input int e, input int s);
    return {8'(e * 7 + s), 8'(e ^ s ^ 8'h5A), 8'(~(e + s))};
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    rd_sel = sel;
    #1 v = rd_data;
  endtask

  task automatic look(input int idx, output logic [23:0] v);
    @(negedge clk);
    pix = 8'(idx);
    @(negedge clk);
    v = rgb;
  endtask

  // write first n words of the group at base, colours from seed s
  task automatic feed(input int base, input int s, input int n);
    logic [7:0] b [12];
    logic [23:0] c;
    for (int k = 0; k < 4; k++) begin
      c = col((base + k) & 255, s);
      b[3*k] = c[23:16]; b[3*k+1] = c[15:8]; b[3*k+2] = c[7:0];
    end
    for (int w = 0; w < n; w++) begin
      wr(2'd1, {b[4*w], b[4*w+1], b[4*w+2], b[4*w+3]});
      if (w == 0) model[base & 255] = col(base & 255, s);
      if (w == 1) model[(base + 1) & 255] = col((base + 1) & 255, s);
      if (w == 2) begin
        model[(base + 2) & 255] = col((base + 2) & 255, s);
        model[(base + 3) & 255] = col((base + 3) & 255, s);
      end
    end
  endtask

  task automatic t_reset();
    logic [31:0] v; logic [23:0] p;
    rd(2'd0, v); chk("R1 index", v, 0);
    rd(2'd3, v); chk("R1 vctl", v, 0);
    rd(2'd2, v); chk("R1 dac", v, 0);
    look(0, p);  chk("R1 rgb", 32'(p), 0);
  endtask

  task automatic t_regs();
    logic [31:0] v; logic [23:0] p;
    wr(2'd0, 32'hFFFF_FF37); rd(2'd0, v); chk("R2 index readback", v, 32'h37);
    wr(2'd3, 32'h0000_009F); rd(2'd3, v); chk("R2 vctl readback", v, 32'h9F);
    look(0, p); chk("R8 blank with 0x9F", 32'(p), 0);
  endtask

  task automatic t_dac();
    logic [31:0] v;
    logic [7:0] vals [4] = '{8'hFF, 8'h00, 8'h70, 8'h00};
    for (int i = 0; i < 4; i++) begin
      wr(2'd0, 32'(4 + i)); wr(2'd2, 32'(vals[i]));
    end
    for (int i = 3; i >= 0; i--) begin
      wr(2'd0, 32'(4 + i)); rd(2'd2, v); chk("R9 dac slot", v, 32'(vals[i]));
    end
  endtask

  task automatic t_group();
    logic [23:0] p;
    wr(2'd3, 32'h40);
    wr(2'd0, 32'h0A);
    feed(8, 3, 3);
    for (int e = 8; e < 12; e++) begin
      look(e, p); chk("R3 R6 group entry", 32'(p), 32'(model[e]));
    end
  endtask

  task automatic t_partial();
    logic [23:0] p;
    wr(2'd0, 32'd16); feed(16, 1, 3);
    wr(2'd0, 32'd16); feed(16, 9, 1);
    look(16, p); chk("R5 word0 commits B", 32'(p), 32'(col(16, 9)));
    look(17, p); chk("R5 B+1 still old", 32'(p), 32'(col(17, 1)));
    feed_cont(16, 9, 1);
    look(17, p); chk("R5 word1 commits B+1", 32'(p), 32'(col(17, 9)));
    look(18, p); chk("R5 B+2 still old", 32'(p), 32'(col(18, 1)));
    feed_cont(16, 9, 2);
    look(18, p); chk("R5 word2 entry B+2", 32'(p), 32'(col(18, 9)));
    look(19, p); chk("R5 word2 entry B+3", 32'(p), 32'(col(19, 9)));
  endtask

  // write single word w of a group
  task automatic feed_cont(input int base, input int s, input int w);
    logic [7:0] b [12];
    logic [23:0] c;
    for (int k = 0; k < 4; k++) begin
      c = col(base + k, s);
      b[3*k] = c[23:16]; b[3*k+1] = c[15:8]; b[3*k+2] = c[7:0];
    end
    wr(2'd1, {b[4*w], b[4*w+1], b[4*w+2], b[4*w+3]});
  endtask

  task automatic t_abort();
    logic [23:0] p;
    wr(2'd0, 32'd20); feed(20, 5, 1);
    wr(2'd0, 32'd20); feed(20, 11, 3);
    for (int e = 20; e < 24; e++) begin
      look(e, p); chk("R4 restart after index write", 32'(p), 32'(col(e, 11)));
    end
  endtask

  task automatic t_wrap();
    logic [23:0] p;
    wr(2'd0, 32'hFC);
    feed(252, 2, 3);
    feed(0, 4, 3);
    look(252, p); chk("R7 entry 252", 32'(p), 32'(model[252]));
    look(255, p); chk("R7 entry 255", 32'(p), 32'(model[255]));
    look(0, p);   chk("R7 wrapped entry 0", 32'(p), 32'(col(0, 4)));
    look(3, p);   chk("R7 wrapped entry 3", 32'(p), 32'(col(3, 4)));
  endtask

  task automatic t_blank();
    logic [23:0] p;
    wr(2'd3, 32'hBF);
    look(9, p); chk("R8 blanked, others set", 32'(p), 0);
    wr(2'd3, 32'hFF);
    look(9, p); chk("R8 other bits no effect", 32'(p), 32'(model[9]));
    wr(2'd3, 32'h40);
    @(negedge clk); pix = 8'd10;
    chk("R6 output before edge", 32'(rgb), 32'(model[9]));
    @(negedge clk);
    chk("R6 output after one edge", 32'(rgb), 32'(model[10]));
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_dac();
    t_group();
    t_partial();
    t_abort();
    t_wrap();
    t_blank();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule